// File: doc/BRIEF.md
# Medium-Infrared Receive Deframer

This block takes a recovered medium-infrared bit stream, one bit per bit-enable tick. It hunts for the flag pattern and drops the opening flags. It removes the zero that the sender stuffs after each run of five ones. It packs the remaining bits into bytes, least significant bit first. A closing flag marks the end of the frame. Payload bytes leave on a valid strobe, and the final payload byte carries an end marker. The two bytes just before the closing flag are the frame check sequence, and they are never delivered.

When a frame ends, the block pulses an end strobe. It also sets sticky status bits for abort, CRC error and length error, which stay set until a clear strobe. The local transmitter drives a receive-disable input. While that input is high, every tick is ignored and the receiver keeps its state, so a frame interrupted this way carries on normally once the input drops.

Top module: `mir_rx_deframer`

## Requirements
- R1: A flag is a 0, then six 1s, then a 0. Flags before the payload, including back-to-back flags with no data between them, produce no output byte and no end strobe.
- R2: A 0 that follows five consecutive 1s inside a frame is removed before byte assembly. Bytes are assembled least significant bit first.
- R3: The tick that carries a closing flag's final 0 ends a frame that holds data. One cycle later `frm_end` pulses, and the last payload byte is presented with `out_valid` and `out_last` both high. No other byte carries `out_last`.
- R4: The final two assembled bytes of a frame are treated as the frame check sequence and are not delivered. Every byte before them is delivered exactly once and in order.
- R5: The CRC check runs a reflected CRC-16 with polynomial 0x8408 and initial value 0xFFFF over every assembled bit. At frame end, a residue other than 0xF0B8 sets `status[1]`.
- R6: At frame end, `status[2]` is set if the number of destuffed bits is not a multiple of 8. It is also set if the payload byte count (frame bytes minus two) is greater than `max_len`. A payload of exactly `max_len` bytes does not set it.
- R7: Seven consecutive 1s during a frame that holds data set `status[0]` and pulse `frm_end` with no `out_last`. The receiver then ignores data until the next flag.
- R8: While `rx_block` is high, ticks have no effect: no output appears, and the frame in progress resumes unchanged once `rx_block` is low.
- R9: Status bits stay set until `stat_clr`. If a clear and a frame-end event fall in the same cycle, the old bits are cleared and the new event's bits are set.
- R10: After reset, `out_valid`, `out_last`, `frm_end` and `status` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Recovered bit tick |
| bit_in | input | 1 | Received line bit, valid when `bit_en` is high |
| rx_block | input | 1 | Receive disable, driven while the local transmitter is active |
| stat_clr | input | 1 | Clears the sticky status bits |
| max_len | input | LENW | Largest payload byte count accepted |
| out_valid | output | 1 | Payload byte strobe |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Marks the final payload byte of a frame |
| frm_end | output | 1 | One-cycle pulse at frame end or abort |
| status | output | 3 | Sticky status: bit 0 abort, bit 1 CRC error, bit 2 length error |

## Verification
Two functions can fall in the same cycle: the status update at frame end and the software clear of the status bits. The bench first leaves a CRC error latched. It then sends an over-length frame and raises `stat_clr` together with the tick of that frame's final flag bit. The status read at the end strobe must then be exactly the length-error bit, which shows that the old CRC error was cleared and the new event was kept. A second collision, between ticks and the receive-disable input, is provoked by injecting blocked ticks full of ones into the middle of a frame. That frame must still come out intact.

// File: rtl/mir_rx_deframer.sv
module mir_rx_deframer #(
  parameter int LENW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            bit_in,
  input  logic            rx_block,
  input  logic            stat_clr,
  input  logic [LENW-1:0] max_len,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            out_last,
  output logic            frm_end,
  output logic [2:0]      status
);

  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h8408;
  localparam logic [15:0] CRC_GOOD = 16'hF0B8;
  localparam logic [LENW-1:0] BCNT_MAX = '1;

  logic            in_frame, had_bits;
  logic [2:0]      ones;
  logic [5:0]      dly;
  logic [2:0]      fill;
  logic [7:0]      asmb;
  logic [2:0]      acnt;
  logic [7:0]      h0, h1, h2;
  logic [1:0]      hcnt;
  logic [15:0]     crc;
  logic [LENW-1:0] bcnt;

  logic tick, is_flag, is_abort, push, pop, pbit, byte_done;
  logic frame_close, abort_evt, len_bad, crc_bad;
  logic [7:0]  new_byte;
  logic [15:0] crc_next;
  logic [2:0]  set_bits;
  logic [LENW:0] lim;

  assign tick      = bit_en & ~rx_block;
  assign is_flag   = tick & ~bit_in & (ones == 3'd6);
  assign is_abort  = tick &  bit_in & (ones == 3'd6);
  assign push      = tick & in_frame & (ones < 3'd5);
  assign pop       = push & (fill == 3'd6);
  assign pbit      = dly[5];
  assign byte_done = pop & (acnt == 3'd7);
  assign new_byte  = {pbit, asmb[7:1]};
  assign crc_next  = (crc >> 1) ^ ((crc[0] ^ pbit) ? CRC_POLY : 16'h0000);

  assign lim         = {1'b0, max_len} + (LENW+1)'(2);
  assign len_bad     = (acnt != 3'd0) | ({1'b0, bcnt} > lim);
  assign crc_bad     = (crc != CRC_GOOD);
  assign frame_close = is_flag & had_bits;
  assign abort_evt   = is_abort & had_bits;
  assign set_bits    = {frame_close & len_bad, frame_close & crc_bad, abort_evt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame  <= 1'b0;
      had_bits  <= 1'b0;
      ones      <= '0;
      dly       <= '0;
      fill      <= '0;
      asmb      <= '0;
      acnt      <= '0;
      h0        <= '0;
      h1        <= '0;
      h2        <= '0;
      hcnt      <= '0;
      crc       <= CRC_INIT;
      bcnt      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      frm_end   <= 1'b0;
      status    <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      frm_end   <= frame_close | abort_evt;
      status    <= (stat_clr ? 3'b000 : status) | set_bits;

      if (tick)
        ones <= bit_in ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;

      if (is_flag | is_abort) begin
        in_frame <= is_flag;
        had_bits <= 1'b0;
        fill     <= '0;
        acnt     <= '0;
        hcnt     <= '0;
        crc      <= CRC_INIT;
        bcnt     <= '0;
      end else if (push) begin
        dly  <= {dly[4:0], bit_in};
        fill <= (fill == 3'd6) ? 3'd6 : fill + 3'd1;
        if (pop) begin
          had_bits <= 1'b1;
          crc      <= crc_next;
          asmb     <= new_byte;
          acnt     <= acnt + 3'd1;
        end
        if (byte_done) begin
          bcnt <= (bcnt == BCNT_MAX) ? bcnt : bcnt + 1'b1;
          h0   <= new_byte;
          h1   <= h0;
          h2   <= h1;
          hcnt <= (hcnt == 2'd3) ? 2'd3 : hcnt + 2'd1;
          if (hcnt == 2'd3) begin
            out_valid <= 1'b1;
            out_data  <= h2;
          end
        end
      end

      if (frame_close && hcnt == 2'd3) begin
        out_valid <= 1'b1;
        out_data  <= h2;
        out_last  <= 1'b1;
      end
    end
  end

endmodule

module mir_rx_deframer_chk #(
  parameter int LENW = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       rx_block,
  input logic       stat_clr,
  input logic       out_valid,
  input logic       out_last,
  input logic       frm_end,
  input logic [2:0] status
);

  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);  // R3

  AST_LAST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> frm_end);  // R3

  AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && !rx_block) |=> (!out_valid && !frm_end));  // R8

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> ((status & $past(status)) == $past(status)));  // R9

  AST_STATUS_MOVES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> ((status == $past(status)) || frm_end));  // R9

  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> ((status == 3'b000) || frm_end));  // R9

endmodule

bind mir_rx_deframer mir_rx_deframer_chk #(.LENW(LENW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_block(rx_block),
  .stat_clr(stat_clr), .out_valid(out_valid), .out_last(out_last),
  .frm_end(frm_end), .status(status)
);

// File: tb/test_mir_rx_deframer.sv
module test_mir_rx_deframer;
  localparam int LENW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, bit_in = 1'b0, rx_block = 1'b0, stat_clr = 1'b0;
  logic [LENW-1:0] max_len = 12'd64;
  logic out_valid, out_last, frm_end;
  logic [7:0] out_data;
  logic [2:0] status;

  always #5 clk = ~clk;

  mir_rx_deframer #(.LENW(LENW)) i_mir_rx_deframer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .rx_block(rx_block), .stat_clr(stat_clr), .max_len(max_len),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .frm_end(frm_end), .status(status)
  );

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  logic [7:0] got[$];
  int last_pos[$];
  int end_cnt = 0;
  logic [2:0] end_stat = 3'b000;
  bit blocked_out = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (out_last) last_pos.push_back(got.size());
      got.push_back(out_data);
    end
    if (frm_end) begin
      end_cnt++;
      end_stat = status;
    end
    if (rx_block && (out_valid || frm_end)) blocked_out = 1'b1;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  bit stream[$];
  int run1;

  function automatic logic [15:0] crc_bit(logic [15:0] c, bit b);
    return (c >> 1) ^ ((c[0] ^ b) ? 16'h8408 : 16'h0000);
  endfunction

  task automatic put_flag();
    stream.push_back(1'b0);
    for (int i = 0; i < 6; i++) stream.push_back(1'b1);
    stream.push_back(1'b0);
    run1 = 0;
  endtask

  task automatic put_data(bit b);
    stream.push_back(b);
    if (b) begin
      run1++;
      if (run1 == 5) begin
        stream.push_back(1'b0);
        run1 = 0;
      end
    end else run1 = 0;
  endtask

  task automatic build(input logic [7:0] pl[$], int nflags, bit corrupt,
                       int extra, bit close);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    logic [7:0] body[$];
    stream.delete();
    for (int f = 0; f < nflags; f++) put_flag();
    foreach (pl[i]) for (int k = 0; k < 8; k++) c = crc_bit(c, pl[i][k]);
    fcs = ~c;
    body = pl;
    if (corrupt) body[0][0] = ~body[0][0];
    body.push_back(fcs[7:0]);
    body.push_back(fcs[15:8]);
    foreach (body[i]) for (int k = 0; k < 8; k++) put_data(body[i][k]);
    for (int e = 0; e < extra; e++) put_data(1'b0);
    if (close) put_flag();
  endtask

  task automatic send_stream(int block_at, bit clr_last);
    foreach (stream[i]) begin
      if (i == block_at) begin
        rx_block = 1'b1;
        for (int j = 0; j < 9; j++) begin
          @(negedge clk);
          bit_en = 1'b1;
          bit_in = (j == 3) ? 1'b0 : 1'b1;
        end
        @(negedge clk);
        bit_en = 1'b0;
        rx_block = 1'b0;
      end
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = stream[i];
      stat_clr = clr_last && (i == stream.size() - 1);
      @(negedge clk);
      bit_en = 1'b0;
      stat_clr = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_status();
    @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  task automatic reset_obs();
    got.delete();
    last_pos.delete();
    end_cnt = 0;
    end_stat = 3'b000;
  endtask

  task automatic check_payload(string req, logic [7:0] pl[$]);
    bit same = (got.size() == pl.size());
    if (same) foreach (pl[i]) if (got[i] !== pl[i]) same = 1'b0;
    chk(same, req, "payload bytes (count)", got.size(), pl.size());
    chk(last_pos.size() == 1 && last_pos[0] == pl.size() - 1, "R3",
        "out_last position", last_pos.size() ? last_pos[0] : -1, pl.size() - 1);
    chk(end_cnt == 1, "R3", "frame end pulses", end_cnt, 1);
  endtask

  function automatic logic [7:0] rnd_byte();
    int r = $urandom % 10;
    if (r < 3) return 8'hFF;
    if (r < 4) return 8'h7E;
    if (r < 5) return 8'h3F;
    return 8'($urandom);
  endfunction

  initial begin
    logic [7:0] pl[$];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_last == 0 && frm_end == 0, "R10", "outputs at reset",
        {out_valid, out_last, frm_end}, 0);
    chk(status == 3'b000, "R10", "status at reset", status, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: flags only
    reset_obs();
    stream.delete();
    for (int f = 0; f < 4; f++) put_flag();
    send_stream(-1, 1'b0);
    chk(got.size() == 0 && end_cnt == 0, "R1", "output from bare flags",
        got.size() + end_cnt, 0);

    // R1 R2 R3 R4 R5: random good frames
    for (int n = 0; n < 10; n++) begin
      pl.delete();
      for (int i = 0; i < 1 + int'($urandom % 16); i++) pl.push_back(rnd_byte());
      reset_obs();
      build(pl, 1 + int'($urandom % 3), 1'b0, 0, 1'b1);
      send_stream(-1, 1'b0);
      check_payload("R4", pl);
      chk(end_stat == 3'b000, "R5", "status of good frame", end_stat, 0);
    end

    // R2: all ones payload
    pl = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    reset_obs();
    build(pl, 2, 1'b0, 0, 1'b1);
    send_stream(-1, 1'b0);
    check_payload("R2", pl);
    chk(end_stat == 3'b000, "R2", "status of stuffed frame", end_stat, 0);

    // R5: CRC error
    pl = '{8'h11, 8'h22, 8'h33, 8'h44};
    reset_obs();
    build(pl, 1, 1'b1, 0, 1'b1);
    send_stream(-1, 1'b0);
    chk(end_stat == 3'b010, "R5", "status of corrupted frame", end_stat, 3'b010);
    chk(got.size() == 4, "R4", "bytes of corrupted frame", got.size(), 4);

    // R9: sticky across a good frame
    pl = '{8'hA5, 8'h5A};
    reset_obs();
    build(pl, 1, 1'b0, 0, 1'b1);
    send_stream(-1, 1'b0);
    chk(end_stat == 3'b010, "R9", "sticky status after good frame", end_stat, 3'b010);

    // R9: clear coinciding with frame end; R6 over-length
    max_len = 12'd3;
    pl = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    reset_obs();
    build(pl, 1, 1'b0, 0, 1'b1);
    send_stream(-1, 1'b1);
    chk(end_stat == 3'b100, "R9", "status with clear at frame end", end_stat, 3'b100);
    chk(got.size() == 5, "R6", "bytes of over-length frame", got.size(), 5);
    clear_status();
    @(negedge clk);
    chk(status == 3'b000, "R9", "status after clear", status, 0);

    // R6: exactly max_len
    pl = '{8'h0A, 8'h0B, 8'h0C};
    reset_obs();
    build(pl, 1, 1'b0, 0, 1'b1);
    send_stream(-1, 1'b0);
    chk(end_stat == 3'b000, "R6", "status at exactly max length", end_stat, 0);
    max_len = 12'd64;

    // R6: partial byte
    pl = '{8'h10, 8'h20, 8'h30};
    reset_obs();
    build(pl, 1, 1'b0, 3, 1'b1);
    send_stream(-1, 1'b0);
    chk(end_stat[2] == 1'b1 && end_stat[0] == 1'b0, "R6", "length bit for partial byte",
        end_stat, 3'b100);
    clear_status();

    // R7: abort
    pl = '{8'h12, 8'h34, 8'h56};
    reset_obs();
    build(pl, 1, 1'b0, 0, 1'b0);
    for (int i = 0; i < 7; i++) stream.push_back(1'b1);
    stream.push_back(1'b0);
    send_stream(-1, 1'b0);
    chk(end_cnt == 1, "R7", "frame end pulses on abort", end_cnt, 1);
    chk(end_stat == 3'b001, "R7", "status on abort", end_stat, 3'b001);
    chk(last_pos.size() == 0, "R7", "out_last on abort", last_pos.size(), 0);
    clear_status();
    pl = '{8'hC3, 8'h3C, 8'h99};
    reset_obs();
    build(pl, 1, 1'b0, 0, 1'b1);
    send_stream(-1, 1'b0);
    check_payload("R7", pl);
    chk(end_stat == 3'b000, "R7", "status of frame after abort", end_stat, 0);

    // R8: blocked ticks inside a frame
    for (int n = 0; n < 3; n++) begin
      pl.delete();
      for (int i = 0; i < 4 + n; i++) pl.push_back(rnd_byte());
      reset_obs();
      blocked_out = 1'b0;
      build(pl, 1, 1'b0, 0, 1'b1);
      send_stream(12 + int'($urandom % 20), 1'b0);
      check_payload("R8", pl);
      chk(end_stat == 3'b000, "R8", "status after blocked ticks", end_stat, 0);
      chk(!blocked_out, "R8", "output while blocked", blocked_out, 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule